// File: doc/BRIEF.md
# Chip-Select Clock-Enable Power Manager

This block drives the clock-enable (CKE) lines of SDRAM devices, one line per chip select. The default build has two. Each chip select has its own state machine, so one device can sleep while the other keeps working.

Software moves a device into a low-power mode by writing a command code on that chip select's command port. Three modes exist: power-down, self-refresh and deep power-down. If rows are still open when an entry code arrives, the block first issues a precharge-all. Power-down and self-refresh end on their own when an access to that chip select is requested. Deep power-down ends only on an explicit exit code. Leaving deep power-down raises a flag that tells the system the device must be initialised again.

After power-up, each CKE pin carries an externally forced level. It keeps that level until a release input frees it. From then on the internal CKE drives the pin.

States, with their status code:
- ACTIVE (0)
- PRECHG (1): precharge-all before entry
- PDOWN (2)
- SR_ENTRY (3): one-cycle self-refresh entry
- SELFREF (4)
- DPD_ENTRY (5): one-cycle deep power-down entry
- DEEPPD (6)
- WAKE (7): self-refresh exit delay

Transitions:
- ACTIVE goes to PRECHG when an entry code arrives and rows are open.
- ACTIVE goes straight to PDOWN, SR_ENTRY or DPD_ENTRY when an entry code arrives and no rows are open.
- PRECHG goes to the stored target.
- PDOWN goes to ACTIVE on an access or an exit code.
- SR_ENTRY goes to SELFREF.
- SELFREF goes to WAKE on an access or an exit code.
- WAKE goes to ACTIVE when its delay expires.
- DPD_ENTRY goes to DEEPPD.
- DEEPPD goes to ACTIVE on an exit code only.

Top module: `cke_power_manager`

## Requirements
- R1: After reset every chip select reports status 0 (ACTIVE), its command output is NOP (code 0) and its reinit flag is low. The status codes are 0 ACTIVE, 1 PRECHG, 2 PDOWN, 3 SR_ENTRY, 4 SELFREF, 5 DPD_ENTRY, 6 DEEPPD and 7 WAKE.
- R2: From reset, each CKE pin follows its force level input. A cycle with that chip select's release bit high frees the pin from the next cycle on, and the release is permanent. A freed pin shows the internal CKE, which is high in states 0, 1 and 7 and low in all others.
- R3: In ACTIVE with no open rows, the entry codes move the chip select on the next cycle. Code 1 goes to PDOWN, code 2 to SR_ENTRY and code 3 to DPD_ENTRY.
- R4: In ACTIVE with rows open, an entry code first spends one PRECHG cycle, with CKE high and command 1 (precharge-all), and then moves to the requested mode.
- R5: PDOWN holds CKE low with command NOP. It returns to ACTIVE on the next cycle when an access is requested or code 4 (exit) arrives. An access is granted in the same cycle only while the chip select is ACTIVE.
- R6: Self-refresh entry is one SR_ENTRY cycle, with CKE low and command 2 (auto-refresh), followed by SELFREF.
- R7: In SELFREF, an access or code 4 moves the chip select to WAKE. WAKE holds CKE high for exit_dly+1 cycles and then returns to ACTIVE. exit_dly is sampled on the cycle the exit is taken.
- R8: Deep power-down entry is one DPD_ENTRY cycle, with CKE low and command 3 (burst terminate), followed by DEEPPD.
- R9: In DPD_ENTRY and DEEPPD an access request does not wake the device; it raises the error output in the same cycle. Only code 4 takes DEEPPD back to ACTIVE.
- R10: The reinit flag is set when DEEPPD is left. Code 5 clears it, in any state.
- R11: Commands and accesses on one chip select never change the state or outputs of another.
- R12: Codes that do not apply in the current state have no effect. This covers:
  - codes 0 and 6 to 15 in every state;
  - code 4 in ACTIVE;
  - entry codes in any low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | NUM_CS | Command strobe per chip select |
| cmd_code | input | 4*NUM_CS | Command code per chip select, 4 bits each |
| acc_req | input | NUM_CS | Access request per chip select |
| rows_open | input | NUM_CS | Open rows present on the chip select |
| exit_dly | input | DLY_W | Self-refresh exit delay in cycles |
| force_lvl | input | NUM_CS | Forced CKE level used until release |
| force_rel | input | NUM_CS | Release of the CKE force |
| cke_pin | output | NUM_CS | CKE output per chip select |
| mem_cmd | output | 3*NUM_CS | Memory command per chip select (0 NOP, 1 precharge-all, 2 auto-refresh, 3 burst terminate) |
| cs_status | output | 3*NUM_CS | State code per chip select |
| acc_grant | output | NUM_CS | Access accepted this cycle |
| acc_err | output | NUM_CS | Access rejected because of deep power-down |
| reinit_req | output | NUM_CS | Re-initialisation needed after deep power-down |

## Verification
The assertions take for granted that every input is a known value at each rising clock edge after reset. They also take for granted that rows_open truthfully reports open rows, and that a precharge-all cycle closes them, so a requested mode is always reached after one PRECHG cycle.

The stimulus changes inputs only on falling edges. It draws codes from 0 to 6, so unused codes are hit often. It keeps exit_dly between 0 and 4, so WAKE periods both of one cycle and of several cycles appear many times within the run.

// File: rtl/cke_pm_pkg.sv
package cke_pm_pkg;

    localparam int CMD_W   = 4;
    localparam int STATE_W = 3;
    localparam int MCMD_W  = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_ACTIVE    = 3'd0,
        ST_PRECHG    = 3'd1,
        ST_PDOWN     = 3'd2,
        ST_SR_ENTRY  = 3'd3,
        ST_SELFREF   = 3'd4,
        ST_DPD_ENTRY = 3'd5,
        ST_DEEPPD    = 3'd6,
        ST_WAKE      = 3'd7
    } cs_state_e;

    // software command codes
    localparam logic [CMD_W-1:0] OP_ENTER_PD  = 4'd1;
    localparam logic [CMD_W-1:0] OP_ENTER_SR  = 4'd2;
    localparam logic [CMD_W-1:0] OP_ENTER_DPD = 4'd3;
    localparam logic [CMD_W-1:0] OP_EXIT_LP   = 4'd4;
    localparam logic [CMD_W-1:0] OP_REINIT_OK = 4'd5;

    // memory command codes
    localparam logic [MCMD_W-1:0] MC_NOP     = 3'd0;
    localparam logic [MCMD_W-1:0] MC_PRE_ALL = 3'd1;
    localparam logic [MCMD_W-1:0] MC_AREF    = 3'd2;
    localparam logic [MCMD_W-1:0] MC_BST     = 3'd3;

endpackage

// File: rtl/cke_wake_timer.sv
module cke_wake_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/cke_force_gate.sv
module cke_force_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic force_lvl,
    input  logic force_rel,
    input  logic cke_int,
    output logic cke_pin
);

    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
        end else if (force_rel) begin
            hold_q <= 1'b0;
        end
    end

    assign cke_pin = hold_q ? force_lvl : cke_int;

    // R2: once released, the force never returns
    assert_release_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_q |=> !hold_q);

    // R2: the force stays until a release arrives
    assert_hold_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !force_rel) |=> hold_q);

endmodule

// File: rtl/cke_cs_fsm.sv
module cke_cs_fsm
    import cke_pm_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd_code,
    input  logic               acc_req,
    input  logic               rows_open,
    input  logic [DLY_W-1:0]   exit_dly,
    output logic               cke_int,
    output logic [MCMD_W-1:0]  mem_cmd,
    output logic [STATE_W-1:0] status,
    output logic               acc_grant,
    output logic               acc_err,
    output logic               reinit_req
);

    cs_state_e state_q, state_d;
    cs_state_e target_q, entry_tgt;
    logic      is_entry, exit_op, ack_op;
    logic      tmr_load, tmr_run, tmr_done;
    logic      reinit_q;

    // command decode
    always_comb begin
        is_entry  = 1'b0;
        entry_tgt = ST_PDOWN;
        if (cmd_valid) begin
            unique case (cmd_code)
                OP_ENTER_PD:  begin is_entry = 1'b1; entry_tgt = ST_PDOWN;     end
                OP_ENTER_SR:  begin is_entry = 1'b1; entry_tgt = ST_SR_ENTRY;  end
                OP_ENTER_DPD: begin is_entry = 1'b1; entry_tgt = ST_DPD_ENTRY; end
                default:      begin is_entry = 1'b0; entry_tgt = ST_PDOWN;     end
            endcase
        end
    end

    assign exit_op = cmd_valid && (cmd_code == OP_EXIT_LP);
    assign ack_op  = cmd_valid && (cmd_code == OP_REINIT_OK);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:    if (is_entry) state_d = rows_open ? ST_PRECHG : entry_tgt;
            ST_PRECHG:    state_d = target_q;
            ST_PDOWN:     if (acc_req || exit_op) state_d = ST_ACTIVE;
            ST_SR_ENTRY:  state_d = ST_SELFREF;
            ST_SELFREF:   if (acc_req || exit_op) state_d = ST_WAKE;
            ST_DPD_ENTRY: state_d = ST_DEEPPD;
            ST_DEEPPD:    if (exit_op) state_d = ST_ACTIVE;
            ST_WAKE:      if (tmr_done) state_d = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ACTIVE;
            target_q <= ST_PDOWN;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACTIVE && is_entry) begin
                target_q <= entry_tgt;
            end
        end
    end

    // re-initialisation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reinit_q <= 1'b0;
        end else if (state_q == ST_DEEPPD && exit_op) begin
            reinit_q <= 1'b1;
        end else if (ack_op) begin
            reinit_q <= 1'b0;
        end
    end

    assign tmr_load = (state_q == ST_SELFREF) && (state_d == ST_WAKE);
    assign tmr_run  = (state_q == ST_WAKE);

    cke_wake_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (exit_dly),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    // outputs
    always_comb begin
        cke_int   = 1'b1;
        mem_cmd   = MC_NOP;
        acc_grant = 1'b0;
        acc_err   = 1'b0;
        unique case (state_q)
            ST_ACTIVE:    acc_grant = acc_req;
            ST_PRECHG:    mem_cmd = MC_PRE_ALL;
            ST_PDOWN:     cke_int = 1'b0;
            ST_SR_ENTRY:  begin cke_int = 1'b0; mem_cmd = MC_AREF; end
            ST_SELFREF:   cke_int = 1'b0;
            ST_DPD_ENTRY: begin cke_int = 1'b0; mem_cmd = MC_BST; acc_err = acc_req; end
            ST_DEEPPD:    begin cke_int = 1'b0; acc_err = acc_req; end
            ST_WAKE:      cke_int = 1'b1;
        endcase
    end

    assign status     = state_q;
    assign reinit_req = reinit_q;

    // R9: deep power-down holds without an exit code
    assert_dpd_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEPPD && !exit_op) |=> (state_q == ST_DEEPPD));

    // R4: precharge cycle leads into a low-CKE state
    assert_prechg_then_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRECHG) |=> !cke_int);

    // R7: wake persists until the timer expires
    assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !tmr_done) |=> (state_q == ST_WAKE));

    // R6: self-refresh entry comes only from ACTIVE or PRECHG
    assert_sr_entry_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR_ENTRY) |-> ($past(state_q) == ST_ACTIVE || $past(state_q) == ST_PRECHG));

    // R5: an access in power-down wakes the device next cycle
    assert_pd_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PDOWN && acc_req) |=> (state_q == ST_ACTIVE));

    // R5/R9: grant and error are exclusive
    assert_grant_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_grant && acc_err));

endmodule

// File: rtl/cke_power_manager.sv
module cke_power_manager
    import cke_pm_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DLY_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CS-1:0]         cmd_valid,
    input  logic [NUM_CS*CMD_W-1:0]   cmd_code,
    input  logic [NUM_CS-1:0]         acc_req,
    input  logic [NUM_CS-1:0]         rows_open,
    input  logic [DLY_W-1:0]          exit_dly,
    input  logic [NUM_CS-1:0]         force_lvl,
    input  logic [NUM_CS-1:0]         force_rel,
    output logic [NUM_CS-1:0]         cke_pin,
    output logic [NUM_CS*MCMD_W-1:0]  mem_cmd,
    output logic [NUM_CS*STATE_W-1:0] cs_status,
    output logic [NUM_CS-1:0]         acc_grant,
    output logic [NUM_CS-1:0]         acc_err,
    output logic [NUM_CS-1:0]         reinit_req
);

    logic [NUM_CS-1:0] cke_int;

    for (genvar cs = 0; cs < NUM_CS; cs++) begin : g_cs
        cke_cs_fsm #(.DLY_W(DLY_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_valid  (cmd_valid[cs]),
            .cmd_code   (cmd_code[cs*CMD_W +: CMD_W]),
            .acc_req    (acc_req[cs]),
            .rows_open  (rows_open[cs]),
            .exit_dly   (exit_dly),
            .cke_int    (cke_int[cs]),
            .mem_cmd    (mem_cmd[cs*MCMD_W +: MCMD_W]),
            .status     (cs_status[cs*STATE_W +: STATE_W]),
            .acc_grant  (acc_grant[cs]),
            .acc_err    (acc_err[cs]),
            .reinit_req (reinit_req[cs])
        );

        cke_force_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_lvl (force_lvl[cs]),
            .force_rel (force_rel[cs]),
            .cke_int   (cke_int[cs]),
            .cke_pin   (cke_pin[cs])
        );
    end

endmodule

// File: tb/cke_power_manager_test.sv
module cke_power_manager_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 2;
    localparam int DW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCS-1:0] cmd_valid = '0;
    logic [NCS*4-1:0] cmd_code = '0;
    logic [NCS-1:0] acc_req = '0;
    logic [NCS-1:0] rows_open = '0;
    logic [DW-1:0]  exit_dly = '0;
    logic [NCS-1:0] force_lvl = '0;
    logic [NCS-1:0] force_rel = '0;
    logic [NCS-1:0] cke_pin;
    logic [NCS*3-1:0] mem_cmd;
    logic [NCS*3-1:0] cs_status;
    logic [NCS-1:0] acc_grant;
    logic [NCS-1:0] acc_err;
    logic [NCS-1:0] reinit_req;

    cke_power_manager #(.NUM_CS(NCS), .DLY_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .acc_req(acc_req), .rows_open(rows_open), .exit_dly(exit_dly),
        .force_lvl(force_lvl), .force_rel(force_rel), .cke_pin(cke_pin),
        .mem_cmd(mem_cmd), .cs_status(cs_status), .acc_grant(acc_grant),
        .acc_err(acc_err), .reinit_req(reinit_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int m_st [NCS];
    int m_tgt[NCS];
    int m_cnt[NCS];
    bit m_re [NCS];
    bit m_hold[NCS];

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_cke(int s);
        return (s == 0 || s == 1 || s == 7);
    endfunction

    function automatic int exp_cmd(int s);
        case (s)
            1: return 1;
            3: return 2;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R7";
        endcase
    endfunction

    function automatic int code_of(int cs);
        return int'(cmd_code[cs*4 +: 4]);
    endfunction

    task automatic compare_all();
        for (int cs = 0; cs < NCS; cs++) begin
            int s;
            bit pin, g, e;
            s   = m_st[cs];
            pin = m_hold[cs] ? force_lvl[cs] : exp_cke(s);
            g   = acc_req[cs] && (s == 0);
            e   = acc_req[cs] && (s == 5 || s == 6);
            check(int'(cs_status[cs*3 +: 3]) == s, tag_of(s), int'(cs_status[cs*3 +: 3]), s);
            check(int'(mem_cmd[cs*3 +: 3]) == exp_cmd(s), tag_of(s), int'(mem_cmd[cs*3 +: 3]), exp_cmd(s));
            check(cke_pin[cs] == pin, "R2", int'(cke_pin[cs]), int'(pin));
            check(acc_grant[cs] == g, "R5", int'(acc_grant[cs]), int'(g));
            check(acc_err[cs] == e, "R9", int'(acc_err[cs]), int'(e));
            check(reinit_req[cs] == m_re[cs], "R10", int'(reinit_req[cs]), int'(m_re[cs]));
        end
    endtask

    task automatic model_edge();
        for (int cs = 0; cs < NCS; cs++) begin
            int s, c, nx;
            bit v, entry, ex;
            s  = m_st[cs];
            v  = cmd_valid[cs];
            c  = code_of(cs);
            entry = v && (c >= 1 && c <= 3);
            ex    = v && (c == 4);
            nx = s;
            case (s)
                0: if (entry) begin
                       m_tgt[cs] = (c == 1) ? 2 : (c == 2) ? 3 : 5;
                       nx = rows_open[cs] ? 1 : m_tgt[cs];
                   end
                1: nx = m_tgt[cs];
                2: if (acc_req[cs] || ex) nx = 0;
                3: nx = 4;
                4: if (acc_req[cs] || ex) begin nx = 7; m_cnt[cs] = int'(exit_dly); end
                5: nx = 6;
                6: if (ex) nx = 0;
                default: if (m_cnt[cs] == 0) nx = 0; else m_cnt[cs]--;
            endcase
            if (s == 6 && ex) m_re[cs] = 1'b1;
            else if (v && c == 5) m_re[cs] = 1'b0;
            if (force_rel[cs]) m_hold[cs] = 1'b0;
            m_st[cs] = nx;
        end
    endtask

    task automatic step();
        #1;
        compare_all();
        model_edge();
        @(negedge clk);
    endtask

    task automatic quiet();
        cmd_valid = '0;
        cmd_code  = '0;
        acc_req   = '0;
        force_rel = '0;
    endtask

    task automatic op(int cs, int code, bit acc);
        quiet();
        cmd_valid[cs]       = (code != 0);
        cmd_code[cs*4 +: 4] = 4'(code);
        acc_req[cs]         = acc;
        step();
        quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int cs = 0; cs < NCS; cs++) begin
            m_st[cs] = 0; m_tgt[cs] = 2; m_cnt[cs] = 0; m_re[cs] = 0; m_hold[cs] = 1;
        end
        force_lvl = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int cs = 0; cs < NCS; cs++) begin
            check(cs_status[cs*3 +: 3] == 3'd0, "R1", int'(cs_status[cs*3 +: 3]), 0);
            check(mem_cmd[cs*3 +: 3] == 3'd0, "R1", int'(mem_cmd[cs*3 +: 3]), 0);
            check(reinit_req[cs] == 1'b0, "R1", int'(reinit_req[cs]), 0);
            check(cke_pin[cs] == force_lvl[cs], "R2", int'(cke_pin[cs]), int'(force_lvl[cs]));
        end
        // R2: force held, then released
        op(0, 1, 0);
        op(0, 4, 0);
        force_lvl = 2'b10;
        step();
        force_rel = 2'b11;
        step();
        quiet();
        force_lvl = 2'b11;
        step();
        // R3: power-down with no open rows, exit by access (R5)
        rows_open = 2'b00;
        op(0, 1, 0);
        step();
        op(0, 0, 1);
        // R4 + R6 + R7: open rows then self-refresh, exit via access with delay 3
        rows_open = 2'b01;
        exit_dly  = 8'd3;
        op(0, 2, 0);
        step(); step();
        rows_open = 2'b00;
        op(0, 0, 1);
        repeat (5) step();
        check(cs_status[2:0] == 3'd0, "R7", int'(cs_status[2:0]), 0);
        // R8 + R9 + R10: deep power-down on cs1
        op(1, 3, 0);
        step();
        op(1, 0, 1);
        check(cs_status[5:3] == 3'd6, "R9", int'(cs_status[5:3]), 6);
        op(1, 1, 1);
        check(cs_status[5:3] == 3'd6, "R12", int'(cs_status[5:3]), 6);
        op(1, 4, 0);
        check(reinit_req[1] == 1'b1, "R10", int'(reinit_req[1]), 1);
        op(1, 5, 0);
        check(reinit_req[1] == 1'b0, "R10", int'(reinit_req[1]), 0);
        // R11: cs0 activity leaves cs1 idle
        op(0, 1, 0);
        check(cs_status[5:3] == 3'd0, "R11", int'(cs_status[5:3]), 0);
        check(cke_pin[1] == 1'b1, "R11", int'(cke_pin[1]), 1);
        op(0, 4, 0);
        // R12: ignored codes
        op(0, 9, 0);
        check(cs_status[2:0] == 3'd0, "R12", int'(cs_status[2:0]), 0);
        op(0, 4, 0);
        check(cs_status[2:0] == 3'd0, "R12", int'(cs_status[2:0]), 0);
        op(0, 6, 0);
        check(mem_cmd[2:0] == 3'd0, "R12", int'(mem_cmd[2:0]), 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 200 == 0) exit_dly = 8'($urandom_range(0, 4));
            for (int cs = 0; cs < NCS; cs++) begin
                cmd_valid[cs]       = ($urandom_range(0, 3) == 0);
                cmd_code[cs*4 +: 4] = 4'($urandom_range(0, 6));
                acc_req[cs]         = ($urandom_range(0, 4) == 0);
                rows_open[cs]       = 1'($urandom_range(0, 1));
            end
            step();
        end
        quiet();
        step();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule